// File: doc/BRIEF.md
# Factored Shift-Add Constant Multiplier

This block multiplies a signed input word by a fixed integer constant without a general multiplier. The constant is broken into a product of small factors, and each factor is built as a single canonical-signed-digit term pair: the data shifted left by a fixed amount, plus or minus the unshifted data. One such shift-add stage is placed per factor. The stages are chained, so the result of one stage is the input of the next. A constant of 217 is built as 7 times 31 with two subtracting stages: first `t = 8x - x`, then `p = 32t - t`. That costs two adders, where the flat signed-digit expansion `256 - 32 - 4 - 2 - 1` would cost four. The constants 9, 17 and 33 each take a single adding stage of the form `2^k + 1`, which suits symmetric low-pass FIR taps.

A parameter selects the constant at build time. Each stage ends in one register, and a small control pipeline carries the valid flag alongside the data. The product therefore appears a fixed number of clocks after the input, with one result per clock. Every stage widens its result by the bit count of its factor, so the product never wraps.

Top module: `fcsd_const_mult`

## Requirements
- R1: With the constant set to 217, every valid input x gives a product equal to 217·x, computed as 7·x followed by 31 times that result.
- R2: With the constant set to 9, 17 or 33, every valid input x gives a product equal to that constant times x, using one shift-add stage.
- R3: The output valid rises exactly S clocks after the clock edge that samples an asserted input valid, where S is the number of factor stages (2 for 217, 1 for the others). The output valid never appears without a matching input.
- R4: The product width is the input width plus ceil(log2(f)) for every factor f. Each stage result fits its own grown width, so the extreme inputs -2^(W-1) and 2^(W-1)-1 give exact products with no wrap.
- R5: While no new result is delivered, the product output keeps the last delivered value. Cycles with input valid low change nothing downstream.
- R6: After reset the output valid is 0 and the product is 0.
- R7: Inputs on consecutive clocks give consecutive results in the same order, one per clock, with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word is valid this clock |
| inData | input | DATA_W | Signed two's-complement multiplicand |
| outValid | output | 1 | Product is new this clock |
| outProduct | output | PROD_W | Signed product, DATA_W plus the summed factor growth |

## Verification
The hardest case to reach is the two-stage constant with inputs arriving on back-to-back clocks, mixed with gaps. There the second stage must take its operand from the first stage on exactly the clock that the delayed valid arrives. It must also hold its operand while a bubble passes through. The stimulus drives all four constants in parallel from one driver. It runs an unbroken burst, then a long run with randomly dropped valids, so bubbles fall between the two stages in every phase. The extreme signed inputs are placed at the start of the burst. The monitor also confirms on every idle cycle that the product holds its last value.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

  localparam int MAX_STAGES = 2;

  typedef struct packed {
    logic [MAX_STAGES-1:0] stageLoad;
  } fcsd_strobe_t;

  function automatic int stageCount(input int coef);
    case (coef)
      217:        return 2;
      9, 17, 33:  return 1;
      default:    return 0;
    endcase
  endfunction

  function automatic int stageShift(input int coef, input int idx);
    case (coef)
      217:     return (idx == 0) ? 3 : 5;
      9:       return 3;
      17:      return 4;
      33:      return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit stageNegate(input int coef, input int idx);
    if (coef == 217 && idx < 2) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int stageFactor(input int coef, input int idx);
    int base;
    base = 1 << stageShift(coef, idx);
    return stageNegate(coef, idx) ? base - 1 : base + 1;
  endfunction

  function automatic int stageGrowth(input int coef, input int idx);
    return $clog2(stageFactor(coef, idx));
  endfunction

  function automatic int growthUpTo(input int coef, input int n);
    int acc;
    acc = 0;
    for (int i = 0; i < n; i++) acc += stageGrowth(coef, i);
    return acc;
  endfunction

endpackage

// File: rtl/fcsd_ctrl.sv
module fcsd_ctrl
  import fcsd_pkg::*;
#(
  parameter int NSTAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output fcsd_strobe_t strobes,
  output logic         outValid
);

  logic [NSTAGES-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[NSTAGES-2+1-1:0], inValid} >> 0;
  end

  always_comb begin
    strobes = '0;
    strobes.stageLoad[0] = inValid;
    for (int i = 1; i < NSTAGES; i++) strobes.stageLoad[i] = validPipe[i-1];
  end

  assign outValid = validPipe[NSTAGES-1];

  assert_valid_enter_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> validPipe[0]);
  assert_valid_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !validPipe[0]);

endmodule

// File: rtl/fcsd_stage.sv
module fcsd_stage #(
  parameter int PROD_W = 24,
  parameter int SHIFT  = 3,
  parameter bit NEGATE = 1'b1,
  parameter int OUT_W  = 19
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     load,
  input  logic signed [PROD_W-1:0] din,
  output logic signed [PROD_W-1:0] dout
);

  logic signed [PROD_W-1:0] shifted;
  logic signed [PROD_W-1:0] sumNext;

  assign shifted = din <<< SHIFT;

  generate
    if (NEGATE) begin : g_sub
      assign sumNext = shifted - din;
    end else begin : g_add
      assign sumNext = shifted + din;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     dout <= '0;
    else if (load) dout <= sumNext;
  end

  logic [PROD_W-OUT_W:0] topBits;
  assign topBits = dout[PROD_W-1:OUT_W-1];

  assert_stage_fits_R4: assert property (@(posedge clk) disable iff (!rstN)
    (topBits == '0) || (topBits == '1));
  assert_stage_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> $stable(dout));

endmodule

// File: rtl/fcsd_datapath.sv
module fcsd_datapath
  import fcsd_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF    = 217,
  parameter int NSTAGES = 2,
  parameter int PROD_W  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcsd_strobe_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [PROD_W-1:0] product
);

  logic signed [PROD_W-1:0] stageBus [NSTAGES+1];

  assign stageBus[0] = PROD_W'($signed(inData));

  generate
    for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
      localparam int SH   = stageShift(COEF, i);
      localparam bit NEG  = stageNegate(COEF, i);
      localparam int OUTW = DATA_W + growthUpTo(COEF, i + 1);
      fcsd_stage #(
        .PROD_W(PROD_W),
        .SHIFT (SH),
        .NEGATE(NEG),
        .OUT_W (OUTW)
      ) i_stage (
        .clk (clk),
        .rstN(rstN),
        .load(strobes.stageLoad[i]),
        .din (stageBus[i]),
        .dout(stageBus[i+1])
      );
    end
    for (genvar j = NSTAGES; j < MAX_STAGES; j++) begin : g_idle
      assert_idle_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.stageLoad[j]);
    end
  endgenerate

  assign product = stageBus[NSTAGES];

endmodule

// File: rtl/fcsd_const_mult.sv
module fcsd_const_mult
  import fcsd_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int COEF   = 217,
  localparam int NSTAGES = stageCount(COEF),
  localparam int PROD_W  = DATA_W + growthUpTo(COEF, NSTAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [PROD_W-1:0] outProduct
);

  generate
    if (NSTAGES < 1) begin : g_unsupported
      $error("fcsd_const_mult: constant has no factor table");
    end
  endgenerate

  fcsd_strobe_t strobes;

  fcsd_ctrl #(
    .NSTAGES(NSTAGES)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  fcsd_datapath #(
    .DATA_W (DATA_W),
    .COEF   (COEF),
    .NSTAGES(NSTAGES),
    .PROD_W (PROD_W)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .inData (inData),
    .product(outProduct)
  );

  // R1 / R2: delivered product equals the constant times the input sampled NSTAGES edges earlier
  assert_product_exact_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (longint'($signed(outProduct)) ==
                  longint'(COEF) * longint'($signed($past(inData, NSTAGES)))));
  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, NSTAGES));
  assert_product_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outProduct));

endmodule

// File: tb/test_fcsd_const_mult.sv
module test_fcsd_const_mult;

  typedef struct {
    longint val;
    int     due;
    string  tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [15:0] inData = '0;

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  int kCoef  [4] = '{217, 9, 17, 33};
  int kStage [4] = '{2, 1, 1, 1};

  logic [3:0] outV;
  logic signed [23:0] p217;
  logic signed [19:0] p9;
  logic signed [20:0] p17;
  logic signed [21:0] p33;
  logic signed [31:0] prodX [4];

  fcsd_const_mult #(.DATA_W(16), .COEF(217)) i_fcsd_const_mult (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outV[0]), .outProduct(p217));
  fcsd_const_mult #(.DATA_W(16), .COEF(9)) i_fcsd_const_mult_9 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outV[1]), .outProduct(p9));
  fcsd_const_mult #(.DATA_W(16), .COEF(17)) i_fcsd_const_mult_17 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outV[2]), .outProduct(p17));
  fcsd_const_mult #(.DATA_W(16), .COEF(33)) i_fcsd_const_mult_33 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outV[3]), .outProduct(p33));

  assign prodX[0] = 32'(p217);
  assign prodX[1] = 32'(p9);
  assign prodX[2] = 32'(p17);
  assign prodX[3] = 32'(p33);

  item_t  expQ [4][$];
  longint lastProd [4] = '{0, 0, 0, 0};

  task automatic check(input bit ok, input string tag, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: presents one word and records the expected item for every constant
  task automatic drive(input logic signed [15:0] x, input string tag);
    @(negedge clk);
    inValid = 1'b1;
    inData  = x;
    for (int k = 0; k < 4; k++) begin
      item_t it;
      it.val = longint'(kCoef[k]) * longint'(x);
      it.due = cyc + kStage[k];
      it.tag = (tag != "") ? tag : ((k == 0) ? "R1" : "R2");
      expQ[k].push_back(it);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inData  = 16'($urandom);
    end
  endtask

  // monitor: compares delivered results and checks holding between them
  always @(negedge clk) begin
    if (running) begin
      for (int k = 0; k < 4; k++) begin
        if (outV[k]) begin
          if (expQ[k].size() == 0) begin
            check(1'b0, "R3 unexpected valid", longint'(k), -1);
          end else begin
            item_t it;
            it = expQ[k].pop_front();
            check(longint'(prodX[k]) == it.val, it.tag, longint'(prodX[k]), it.val);
            check(cyc == it.due, "R3 latency", longint'(cyc), longint'(it.due));
            lastProd[k] = longint'(prodX[k]);
          end
        end else begin
          check(longint'(prodX[k]) == lastProd[k], "R5 hold", longint'(prodX[k]), lastProd[k]);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(outV[k] == 1'b0, "R6 reset valid", longint'(outV[k]), 0);
      check(prodX[k] == 0, "R6 reset product", longint'(prodX[k]), 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;

    // R4 extremes, then an unbroken burst for R7
    drive(16'sh8000, "R4");
    drive(16'sh7FFF, "R4");
    drive(-16'sd1, "R4");
    drive(16'sd0, "R4");
    drive(16'sd1, "R4");
    for (int i = 0; i < 40; i++) drive(16'($urandom), "R7");
    idle(1);
    drive(16'sh8000, "R4");
    idle(1);
    drive(16'sh7FFF, "R4");
    idle(4);

    // random traffic with bubbles
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      drive(16'($urandom), "");
    end
    idle(6);

    for (int k = 0; k < 4; k++)
      check(expQ[k].size() == 0, "R7 drained", longint'(expQ[k].size()), 0);
    running = 1'b0;
    done = 1'b1;
    finishRun();
  end

endmodule